// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block sits on the host side of a 12-bit sampling converter that has a parallel output. It drives the converter's chip-select, conversion-start and output-enable pins, watches the converter's ready line, and returns each conversion result on a valid/ready output port. Each conversion starts when the host pulses `start_req`. There is no free-running sample clock. A request that arrives while a transaction is already running is counted and serviced later.

Four access styles are selected by `cfg_mode`:

- Free conversion: the data outputs stay enabled, and the result is taken on the cycle in which ready returns high.
- Shared bus: the data outputs are enabled only for a read that follows the conversion.
- Slow memory: one combined strobe drives both start and output-enable, and it is held until the conversion finishes.
- Read-ahead: the combined strobe reads the result already held in the converter and starts the next conversion. The value delivered therefore lags one conversion behind.

Every setup, pulse and read interval is a programmable count of system clock cycles. A watchdog count ends any conversion whose ready line never completes its low-then-high sequence.

Top module: `adc_seq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `adc_sel_n`=1, `adc_oe_n`=1, `res_valid`=0 and `err_timeout`=0.
- R2: In mode 0 (free conversion) the start pin is active for exactly max(`cfg_pulse_cyc`,1) cycles. `adc_oe_n` is low for the whole time the converter is selected. The result is the value on `adc_data` in the first cycle in which `adc_ready` is high after it was seen low.
- R3: In modes 0 and 1, `cfg_start_pol`=0 gives a start pin that rests high and pulses low. `cfg_start_pol`=1 gives a start pin that rests low and pulses high.
- R4: In mode 1 (shared bus) `adc_oe_n` goes low only once `adc_ready` has returned high after the conversion. It stays low for max(`cfg_read_cyc`,1) cycles, and the data is captured in the last of those cycles.
- R5: In mode 2 (slow memory) `adc_start` equals `adc_oe_n` while the converter is selected. The strobe stays low from the pulse through the rise of `adc_ready`, plus max(`cfg_read_cyc`,1) cycles. The captured value is the new result.
- R6: In mode 3 (read-ahead) the combined strobe is low for max(`cfg_pulse_cyc`,`cfg_read_cyc`,1) cycles. The value on `adc_data` at the end of the strobe, which is the previous result, is delivered. The next access waits until the conversion started by this strobe has completed.
- R7: `res_stale` is 1 on a mode-3 result when no conversion has completed since reset, and 0 on every other result.
- R8: Requests that arrive while a transaction is running are counted, up to 2^`PEND_W`-1 of them. Each one produces its own conversion and result, in order.
- R9: If `adc_ready` has not gone low and then high within max(`cfg_timeout_cyc`,1) cycles of waiting, `err_timeout` pulses for one cycle, the converter is deselected in that same cycle, and no result is produced.
- R10: While `res_valid`=1 and `res_ready`=0, `res_valid` and `res_data` hold steady, and no new transaction starts.
- R11: `adc_sel_n` is low for max(`cfg_setup_cyc`,1) cycles before the start pin becomes active. `adc_oe_n` is never low while `adc_sel_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_mode | input | 2 | Access style: 0 free, 1 shared bus, 2 slow memory, 3 read-ahead |
| cfg_start_pol | input | 1 | Active level of the start pulse in modes 0 and 1 |
| cfg_setup_cyc | input | CNT_W | Cycles of select before the start pulse |
| cfg_pulse_cyc | input | CNT_W | Start pulse width in cycles |
| cfg_read_cyc | input | CNT_W | Cycles from output enable to data capture |
| cfg_timeout_cyc | input | CNT_W | Maximum cycles to wait for conversion completion |
| start_req | input | 1 | One-cycle request for a conversion |
| adc_sel_n | output | 1 | Converter select, active low |
| adc_start | output | 1 | Conversion start pin; a falling edge begins a conversion |
| adc_oe_n | output | 1 | Converter output enable, active low |
| adc_ready | input | 1 | Low while the converter is converting |
| adc_data | input | DATA_W | Converter parallel data |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | DATA_W | Captured conversion value |
| res_stale | output | 1 | Result predates any completed conversion |
| err_timeout | output | 1 | One-cycle pulse when a conversion times out |

## Verification
The properties check the following on every clock cycle: the pin relationships (combined strobe equal to output enable, output enable only while selected, a shared-bus read only while ready is high), the exact start pulse width, release of the select pin on a timeout, and result stability under backpressure. Other behaviour only the bench scenarios can show. These include which value each mode captures, the one-behind lag and stale flag of read-ahead access, the ordered servicing of stacked requests, the select-to-start setup count, and the recovery after a timeout. They rely on a converter model that holds its previous result until each conversion finishes.

// File: rtl/adc_seq_pkg.sv
// Shared types and pin decode for the conversion sequencer.
// Assumes: the converter begins a conversion on a falling edge of its start pin.
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_SETUP = 3'd1,
        ST_PULSE = 3'd2,
        ST_CONV  = 3'd3,
        ST_READ  = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        MODE_FREE   = 2'd0,
        MODE_SHARED = 2'd1,
        MODE_SLOW   = 2'd2,
        MODE_ROM    = 2'd3
    } seq_mode_e;

    typedef struct packed {
        logic sel_n;
        logic start;
        logic oe_n;
    } pin_set_t;

    // Pin levels that belong to a state in a given access style.
    function automatic pin_set_t decode_pins(seq_state_e st, seq_mode_e m, logic pol);
        pin_set_t p;
        logic     idle;
        logic     strobe;
        idle    = (st == ST_IDLE);
        p.sel_n = idle;
        if (m == MODE_SLOW || m == MODE_ROM) begin
            if (m == MODE_SLOW)
                strobe = (st == ST_PULSE) || (st == ST_CONV) || (st == ST_READ);
            else
                strobe = (st == ST_PULSE);
            p.start = ~strobe;
            p.oe_n  = ~strobe;
        end else begin
            p.start = (st == ST_PULSE) ? pol : ~pol;
            p.oe_n  = (m == MODE_FREE) ? idle : (st != ST_READ);
        end
        return p;
    endfunction

endpackage

// File: rtl/adc_seq_timer.sv
// Down-counter that times one sequencer phase.
// A load of N means expiry in the N-th cycle after the load; N=0 acts as 1.
// Assumes the owner loads it on every phase entry.
module adc_seq_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q <= CNT_W'(1));
endmodule

// File: rtl/adc_seq_pending.sv
// Counts start requests that could not be served at once.
// Saturates at its maximum; the host is assumed never to stack more than that.
module adc_seq_pending #(
    parameter int PEND_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    output logic nonzero
);
    logic [PEND_W-1:0] cnt_q;
    logic              full;

    assign full    = (cnt_q == {PEND_W{1'b1}});
    assign nonzero = (cnt_q != '0);

    // Net change: one up per request, one down per transaction started.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (push && !pop && !full)
            cnt_q <= cnt_q + 1'b1;
        else if (pop && !push && nonzero)
            cnt_q <= cnt_q - 1'b1;
    end
endmodule

// File: rtl/adc_seq_outreg.sv
// Single-entry result register with a valid/ready handshake.
// Assumes load only arrives while the register is empty.
module adc_seq_outreg #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_stale,
    input  logic              ready,
    output logic              valid,
    output logic [DATA_W-1:0] data,
    output logic              stale
);
    // Valid flag: set by a capture, cleared by acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            valid <= 1'b0;
        else if (load)
            valid <= 1'b1;
        else if (ready)
            valid <= 1'b0;
    end

    // Payload: written only on capture, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            stale <= 1'b0;
        end else if (load) begin
            data  <= load_data;
            stale <= load_stale;
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// Host-side sequencer for a parallel-output sampling converter.
// Runs select -> start pulse -> wait for ready -> optional read for each request,
// in one of four access styles, and returns results on a valid/ready port.
// Assumes adc_ready and adc_data are already synchronous to clk and that
// cfg_* inputs change only while the sequencer is idle.
module adc_seq_ctrl #(
    parameter int DATA_W = 12,
    parameter int CNT_W  = 16,
    parameter int PEND_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_start_pol,
    input  logic [CNT_W-1:0]  cfg_setup_cyc,
    input  logic [CNT_W-1:0]  cfg_pulse_cyc,
    input  logic [CNT_W-1:0]  cfg_read_cyc,
    input  logic [CNT_W-1:0]  cfg_timeout_cyc,
    input  logic              start_req,
    output logic              adc_sel_n,
    output logic              adc_start,
    output logic              adc_oe_n,
    input  logic              adc_ready,
    input  logic [DATA_W-1:0] adc_data,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [DATA_W-1:0] res_data,
    output logic              res_stale,
    output logic              err_timeout
);
    import adc_seq_pkg::*;

    seq_state_e       state_q, state_d;
    seq_mode_e        mode_q, mode_d, pin_mode;
    logic             seen_low_q;
    logic             primed_q;
    logic             pend_nz, pend_pop;
    logic             go;
    logic             tm_load, tm_exp;
    logic [CNT_W-1:0] tm_val;
    logic [CNT_W-1:0] pulse_eff;
    logic             cap, cap_stale, conv_done, err_d;
    pin_set_t         pins_d;

    adc_seq_pending #(.PEND_W(PEND_W)) pend_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (start_req),
        .pop     (pend_pop),
        .nonzero (pend_nz)
    );

    adc_seq_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tm_load),
        .load_val (tm_val),
        .expired  (tm_exp)
    );

    adc_seq_outreg #(.DATA_W(DATA_W)) out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cap),
        .load_data  (adc_data),
        .load_stale (cap_stale),
        .ready      (res_ready),
        .valid      (res_valid),
        .data       (res_data),
        .stale      (res_stale)
    );

    // Start a transaction only when a request exists and the result slot is empty.
    assign go = (start_req || pend_nz) && !res_valid;

    // Read-ahead strobe must cover both the pulse and the read delay.
    assign pulse_eff = (mode_q == MODE_ROM && cfg_read_cyc > cfg_pulse_cyc)
                       ? cfg_read_cyc : cfg_pulse_cyc;

    assign cap_stale = (mode_q == MODE_ROM) && !primed_q;

    // Next-state, timer loads, capture and error decisions.
    always_comb begin
        state_d   = state_q;
        mode_d    = mode_q;
        tm_load   = 1'b0;
        tm_val    = '0;
        cap       = 1'b0;
        conv_done = 1'b0;
        err_d     = 1'b0;
        pend_pop  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (go) begin
                    state_d  = ST_SETUP;
                    mode_d   = seq_mode_e'(cfg_mode);
                    tm_load  = 1'b1;
                    tm_val   = cfg_setup_cyc;
                    pend_pop = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tm_exp) begin
                    state_d = ST_PULSE;
                    tm_load = 1'b1;
                    tm_val  = pulse_eff;
                end
            end
            ST_PULSE: begin
                if (tm_exp) begin
                    state_d = ST_CONV;
                    tm_load = 1'b1;
                    tm_val  = cfg_timeout_cyc;
                    cap     = (mode_q == MODE_ROM);
                end
            end
            ST_CONV: begin
                if (seen_low_q && adc_ready) begin
                    conv_done = 1'b1;
                    case (mode_q)
                        MODE_FREE: begin
                            cap     = 1'b1;
                            state_d = ST_IDLE;
                        end
                        MODE_SHARED, MODE_SLOW: begin
                            state_d = ST_READ;
                            tm_load = 1'b1;
                            tm_val  = cfg_read_cyc;
                        end
                        default: state_d = ST_IDLE;
                    endcase
                end else if (tm_exp) begin
                    err_d   = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_READ: begin
                if (tm_exp) begin
                    cap     = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // While idle the pins follow the configured style so rest levels settle deselected.
    assign pin_mode = (state_d == ST_IDLE) ? seq_mode_e'(cfg_mode) : mode_d;
    assign pins_d   = decode_pins(state_d, pin_mode, cfg_start_pol);

    // State, latched mode and error pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            mode_q      <= MODE_FREE;
            err_timeout <= 1'b0;
        end else begin
            state_q     <= state_d;
            mode_q      <= mode_d;
            err_timeout <= err_d;
        end
    end

    // Record that ready went low during this transaction's pulse or wait.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_low_q <= 1'b0;
        else if (state_q == ST_SETUP)
            seen_low_q <= 1'b0;
        else if ((state_q == ST_PULSE || state_q == ST_CONV) && !adc_ready)
            seen_low_q <= 1'b1;
    end

    // Remember that the converter holds a real result.
    always_ff @(posedge clk) begin
        if (!rst_n)
            primed_q <= 1'b0;
        else if (conv_done)
            primed_q <= 1'b1;
    end

    // Glitch-free converter pins registered from the next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adc_sel_n <= 1'b1;
            adc_oe_n  <= 1'b1;
            adc_start <= (cfg_mode[1]) ? 1'b1 : ~cfg_start_pol;
        end else begin
            adc_sel_n <= pins_d.sel_n;
            adc_oe_n  <= pins_d.oe_n;
            adc_start <= pins_d.start;
        end
    end
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
// Property checker for adc_seq_ctrl, attached by bind.
// Assumes cfg_start_pol and cfg_pulse_cyc are stable during a transaction.
module adc_seq_ctrl_chk #(
    parameter int DATA_W = 12,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_start_pol,
    input logic [CNT_W-1:0]  cfg_pulse_cyc,
    input logic [1:0]        mode_q,
    input logic              adc_sel_n,
    input logic              adc_start,
    input logic              adc_oe_n,
    input logic              adc_ready,
    input logic              res_valid,
    input logic              res_ready,
    input logic [DATA_W-1:0] res_data,
    input logic              err_timeout
);
    logic             pulse_act;
    logic [CNT_W:0]   act_cnt;
    logic [CNT_W:0]   pw_eff;

    assign pulse_act = !adc_sel_n && (mode_q == 2'd0 || mode_q == 2'd1) &&
                       (adc_start == cfg_start_pol);
    assign pw_eff    = (cfg_pulse_cyc == '0) ? (CNT_W+1)'(1) : {1'b0, cfg_pulse_cyc};

    // Length of the current active start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_cnt <= '0;
        else if (pulse_act)
            act_cnt <= act_cnt + 1'b1;
        else
            act_cnt <= '0;
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (adc_sel_n && adc_oe_n && !res_valid && !err_timeout));

    assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_act && act_cnt != '0) |-> (act_cnt == pw_eff));

    assert_read_after_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd1 && !adc_oe_n) |-> adc_ready);

    assert_strobe_tied_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[1] && !adc_sel_n) |-> (adc_start == adc_oe_n));

    assert_timeout_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> adc_sel_n);

    assert_timeout_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |=> !err_timeout);

    assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data)));

    assert_oe_needs_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !adc_oe_n |-> !adc_sel_n);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_start_pol (cfg_start_pol),
    .cfg_pulse_cyc (cfg_pulse_cyc),
    .mode_q        (mode_q),
    .adc_sel_n     (adc_sel_n),
    .adc_start     (adc_start),
    .adc_oe_n      (adc_oe_n),
    .adc_ready     (adc_ready),
    .res_valid     (res_valid),
    .res_ready     (res_ready),
    .res_data      (res_data),
    .err_timeout   (err_timeout)
);

// File: tb/adc_seq_ctrl_tb_top.sv
// Scoreboard bench: the driver queues expected results, a monitor compares them.
module adc_seq_ctrl_tb_top;
    localparam int DW     = 12;
    localparam int CW     = 16;
    localparam int CONV_T = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_mode = 2'd3;
    logic          cfg_start_pol = 1'b0;
    logic [CW-1:0] cfg_setup_cyc = 16'd3;
    logic [CW-1:0] cfg_pulse_cyc = 16'd3;
    logic [CW-1:0] cfg_read_cyc = 16'd2;
    logic [CW-1:0] cfg_timeout_cyc = 16'd40;
    logic          start_req = 1'b0;
    logic          adc_sel_n, adc_start, adc_oe_n;
    logic          adc_ready;
    logic [DW-1:0] adc_data;
    logic          res_valid;
    logic          res_ready = 1'b1;
    logic [DW-1:0] res_data;
    logic          res_stale;
    logic          err_timeout;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    adc_seq_ctrl #(.DATA_W(DW), .CNT_W(CW), .PEND_W(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_start_pol(cfg_start_pol),
        .cfg_setup_cyc(cfg_setup_cyc), .cfg_pulse_cyc(cfg_pulse_cyc),
        .cfg_read_cyc(cfg_read_cyc), .cfg_timeout_cyc(cfg_timeout_cyc),
        .start_req(start_req), .adc_sel_n(adc_sel_n), .adc_start(adc_start),
        .adc_oe_n(adc_oe_n), .adc_ready(adc_ready), .adc_data(adc_data),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
        .res_stale(res_stale), .err_timeout(err_timeout)
    );

    function automatic logic [DW-1:0] val(input int k);
        return DW'(256 + k * 53);
    endfunction

    // ---------------- converter model ----------------
    logic [DW-1:0] mdl_res = '0;
    logic          mdl_ready = 1'b1;
    logic          prev_start = 1'b1;
    bit            dead = 1'b0;
    bit            running = 1'b0;
    int            run_t = 0;
    int            mdl_n = 0;

    assign adc_ready = mdl_ready;
    assign adc_data  = (!adc_sel_n && !adc_oe_n) ? mdl_res : 12'hEAD;

    always @(negedge clk) begin
        if (running) begin
            run_t++;
            if (run_t == 1) mdl_ready = 1'b0;
            if (run_t == CONV_T) begin
                mdl_n++;
                mdl_res   = val(mdl_n);
                mdl_ready = 1'b1;
                running   = 1'b0;
            end
        end else if (!dead && rst_n && prev_start === 1'b1 && adc_start === 1'b0 && adc_sel_n === 1'b0) begin
            running = 1'b1;
            run_t   = 0;
        end
        prev_start = adc_start;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [DW-1:0] d;
        logic          s;
        string         tag;
    } exp_t;
    exp_t q[$];
    int   exp_n = 0;

    always @(negedge clk) begin
        if (rst_n && res_valid && res_ready) begin
            n_cmp++;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected result: actual %h expected none", res_data);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (res_data !== e.d || res_stale !== e.s) begin
                    n_bad++;
                    $display("FAIL %s result: actual %h/%b expected %h/%b",
                             e.tag, res_data, res_stale, e.d, e.s);
                end
            end
        end
    end

    // ---------------- pin monitors ----------------
    int  w_cnt = 0, last_w = 0, sel_lo = 0, setup_w = 0;
    bit  got_act = 1'b0;
    int  slow_bad = 0, early_rd = 0, err_seen = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            logic act;
            act = !adc_sel_n && !cfg_mode[1] && (adc_start == cfg_start_pol);
            if (act) w_cnt++;
            else if (w_cnt != 0) begin last_w = w_cnt; w_cnt = 0; end
            if (adc_sel_n) begin sel_lo = 0; got_act = 1'b0; end
            else begin
                if (act && !got_act) begin setup_w = sel_lo; got_act = 1'b1; end
                sel_lo++;
            end
            if (!adc_sel_n && cfg_mode == 2'd2 && adc_start != adc_oe_n) slow_bad++;
            if (!adc_sel_n && cfg_mode == 2'd1 && !adc_oe_n && !adc_ready) early_rd++;
            if (err_timeout) err_seen++;
        end
    end

    // ---------------- driver helpers ----------------
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] m, input int nreq, input string tag);
        cfg_mode = m;
        tick();
        for (int i = 0; i < nreq; i++) begin
            start_req = 1'b1;
            tick();
            start_req = 1'b0;
            if (m == 2'd3) begin
                q.push_back('{d: (exp_n == 0) ? 12'h000 : val(exp_n), s: (exp_n == 0), tag: tag});
                exp_n++;
            end else begin
                exp_n++;
                q.push_back('{d: val(exp_n), s: 1'b0, tag: tag});
            end
        end
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 4) begin
            tick();
            if (q.size() == 0 && adc_sel_n && !running) quiet++;
            else quiet = 0;
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        logic [DW-1:0] held;
        repeat (3) tick();
        // R1: reset state
        check(adc_sel_n === 1'b1, "R1 sel_n", adc_sel_n, 1);
        check(adc_oe_n === 1'b1, "R1 oe_n", adc_oe_n, 1);
        check(res_valid === 1'b0, "R1 res_valid", res_valid, 0);
        check(err_timeout === 1'b0, "R1 err_timeout", err_timeout, 0);
        rst_n = 1'b1;
        repeat (2) tick();

        // R6 R7: first read-ahead access returns a stale empty value
        run(2'd3, 1, "R6_R7 first read-ahead");
        wait_idle();

        // R2 R3 R11: free mode, low pulse, width 3, setup 3
        cfg_start_pol = 1'b0;
        run(2'd0, 1, "R2 free low pulse");
        wait_idle();
        check(last_w == 3, "R2 pulse width", last_w, 3);
        check(setup_w == 3, "R11 setup cycles", setup_w, 3);
        check(adc_start === 1'b1, "R3 rest level pol0", adc_start, 1);

        // R3: high pulse, width 2
        cfg_start_pol = 1'b1;
        cfg_pulse_cyc = 16'd2;
        run(2'd0, 1, "R3 free high pulse");
        wait_idle();
        check(last_w == 2, "R3 pulse width high", last_w, 2);
        check(adc_start === 1'b0, "R3 rest level pol1", adc_start, 0);

        // R4: shared bus read after ready
        cfg_start_pol = 1'b0;
        cfg_pulse_cyc = 16'd3;
        run(2'd1, 1, "R4 shared bus");
        wait_idle();
        check(early_rd == 0, "R4 enable before ready", early_rd, 0);

        // R5: slow memory combined strobe
        run(2'd2, 1, "R5 slow memory");
        wait_idle();
        check(slow_bad == 0, "R5 strobe mismatch cycles", slow_bad, 0);

        // R6 R8: three stacked read-ahead requests, each lagging one behind
        run(2'd3, 3, "R6_R8 read-ahead lag");
        wait_idle();

        // R8: three stacked free conversions
        run(2'd0, 3, "R8 stacked free");
        wait_idle();

        // R10: backpressure holds result and blocks the next transaction
        res_ready = 1'b0;
        run(2'd0, 2, "R10 backpressure");
        while (!res_valid) tick();
        held = res_data;
        repeat (40) tick();
        check(res_valid === 1'b1, "R10 valid held", res_valid, 1);
        check(res_data == held, "R10 data held", res_data, held);
        check(adc_sel_n === 1'b1, "R10 no new transaction", adc_sel_n, 1);
        res_ready = 1'b1;
        wait_idle();

        // R9: converter never responds
        dead = 1'b1;
        cfg_timeout_cyc = 16'd20;
        cfg_mode = 2'd0;
        tick();
        start_req = 1'b1;
        tick();
        start_req = 1'b0;
        for (int i = 0; i < 200 && err_seen == 0; i++) tick();
        repeat (3) tick();
        check(err_seen == 1, "R9 timeout pulses", err_seen, 1);
        check(adc_sel_n === 1'b1, "R9 deselected", adc_sel_n, 1);
        check(res_valid === 1'b0, "R9 no result", res_valid, 0);
        dead = 1'b0;
        cfg_timeout_cyc = 16'd40;

        // R2 R9: zero pulse width acts as one; recovery after timeout
        cfg_pulse_cyc = 16'd0;
        run(2'd0, 1, "R2_R9 recovery width0");
        wait_idle();
        check(last_w == 1, "R2 zero width", last_w, 1);
        check(q.size() == 0, "R8 all results delivered", q.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule